// File: doc/BRIEF.md
# Fuse Array Read Sequencer

This block reads a one-time-programmable fuse array by driving the pins of the fuse macro directly. A request gives a start offset and a unit count. The sequencer then walks the macro through a timed power-up into read mode. It strobes each address in ascending order and hands back every fetched unit on a data output, flagged by a one-cycle valid pulse. After the last unit it parks the macro and pulses `done`.

Two macro profiles are built in, and a static input selects between them:

- **Byte profile:** a 32-entry array read 8 bits at a time. It uses 2 us setup and hold phases and parks in standby.
- **Word profile:** a 128-entry array read 32 bits at a time. It uses 1 us phases and parks in power-down.

Every delay is counted in clock cycles, using a parameter that gives the number of cycles per microsecond. A request that would read past the end of the selected array is refused with an error pulse, and the pins are left untouched.

Top module: `fuse_read_seq`

## Requirements
- R1: While idle, `fuse_ctrl` holds the park word of the selected profile and the strobe bit is low. The byte park word is 0x009 (chip-select-bar and program-enable-bar). The word park word is 0x021 (power-down and chip-select-bar).
- R2: The `fuse_ctrl` bits are as follows:
  - chip-select-bar is bit 0, strobe is bit 1, load is bit 2 and program-enable-bar is bit 3.
  - power-down is bit 5, read-sense-bias is bit 7 and strobe-soft-select is bit 9.
  - The byte profile puts the address in bits 15:6; the word profile puts it in bits 25:16.
- R3: The byte profile enters read mode in two steps. It first drives chip-select-bar alone (0x001) for one cycle. It then drives load with program-enable-bar (0x00C) for 2 us.
- R4: For each byte address, the byte profile drives the address with strobe low for 2 us. It then holds strobe high for 2 us, then drives strobe low with the address held for 2 us.
- R5: The word profile enters read mode by driving load, program-enable-bar, read-sense-bias and strobe-soft-select together (0x28C) for 1 us.
- R6: For each word address, the word profile raises strobe in the same cycle that the address appears. It keeps strobe high for 1 us, then keeps it low for 1 us.
- R7: The unit is sampled from `fuse_dout` in the last strobe-high cycle. It appears on `rd_data` with `rd_valid` high for exactly one cycle, the cycle after that sample, and offsets come out in ascending order. In the byte profile only `fuse_dout[7:0]` is returned, zero-extended.
- R8: `done` pulses for one cycle, in the same cycle that `fuse_ctrl` returns to the park word after the final unit.
- R9: A request with count 0, or with offset plus count greater than the array depth (32 for byte, 128 for word), pulses `err` for one cycle. Such a request yields no `rd_valid` and no change on `fuse_ctrl`.
- R10: While a run is in progress, `req_ready` is low and any new request is ignored.
- R11: A request that ends exactly at the array end (offset plus count equal to the depth) is accepted and reads every unit up to the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_word | input | 1 | Static profile select: 0 byte, 1 word |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_offset | input | ADDR_W | First array offset |
| req_count | input | CNT_W | Number of units to read |
| req_ready | output | 1 | High while idle |
| fuse_ctrl | output | 32 | Fuse macro control pins |
| fuse_dout | input | DATA_W | Fuse macro data output |
| rd_valid | output | 1 | One-cycle pulse with each fetched unit |
| rd_data | output | DATA_W | Fetched unit |
| done | output | 1 | One-cycle pulse at the end of a run |
| err | output | 1 | One-cycle pulse for a rejected request |

## Verification
The assertions check the following on every cycle:

- the strobe-high width for the active profile, and that the pins do not move while strobe is high;
- the single-cycle shape of `rd_valid`;
- that strobe stays low while idle;
- that `done` and `err` only occur with the park word on the pins;
- that the upper data bits are zero in the byte profile.

Only the bench scenarios can show the following:

- the exact order and dwell time of each entry and per-address pin word;
- that the returned values really belong to ascending offsets;
- the acceptance boundary at the array end;
- that a request arriving mid-run is dropped.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;

    localparam int CTRL_W      = 32;
    localparam int B_CSN       = 0;
    localparam int B_STRB      = 1;
    localparam int B_LOAD      = 2;
    localparam int B_PGMN      = 3;
    localparam int B_PDN       = 5;
    localparam int B_RSB       = 7;
    localparam int B_SOFTSEL   = 9;
    localparam int BYTE_ASHIFT = 6;
    localparam int WORD_ASHIFT = 16;
    localparam int ADDR_FIELD  = 10;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SEL,
        S_LOAD,
        S_ADDR,
        S_WENTER,
        S_STRB,
        S_LOW
    } seq_st_e;

endpackage

// File: rtl/fuse_seq_timer.sv
module fuse_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/fuse_seq_range.sv
module fuse_seq_range #(
    parameter int ADDR_W     = 10,
    parameter int CNT_W      = 8,
    parameter int BYTE_DEPTH = 32,
    parameter int WORD_DEPTH = 128
) (
    input  logic              word_mode,
    input  logic [ADDR_W-1:0] offset,
    input  logic [CNT_W-1:0]  count,
    output logic              ok
);
    localparam int SUM_W = ((ADDR_W > CNT_W) ? ADDR_W : CNT_W) + 2;

    logic [SUM_W-1:0] end_pos;
    logic [SUM_W-1:0] depth;

    always_comb begin
        end_pos = SUM_W'(offset) + SUM_W'(count);
        depth   = word_mode ? SUM_W'(WORD_DEPTH) : SUM_W'(BYTE_DEPTH);
        ok      = (count != '0) && (end_pos <= depth);
    end
endmodule

// File: rtl/fuse_seq_pinmap.sv
module fuse_seq_pinmap
    import fuse_seq_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              word_mode,
    input  seq_st_e           st,
    input  logic [ADDR_W-1:0] addr,
    output logic [CTRL_W-1:0] ctrl
);
    localparam logic [CTRL_W-1:0] CSN  = CTRL_W'(1) << B_CSN;
    localparam logic [CTRL_W-1:0] STRB = CTRL_W'(1) << B_STRB;
    localparam logic [CTRL_W-1:0] LOAD = CTRL_W'(1) << B_LOAD;
    localparam logic [CTRL_W-1:0] PGMN = CTRL_W'(1) << B_PGMN;
    localparam logic [CTRL_W-1:0] PDN  = CTRL_W'(1) << B_PDN;
    localparam logic [CTRL_W-1:0] RSB  = CTRL_W'(1) << B_RSB;
    localparam logic [CTRL_W-1:0] SSEL = CTRL_W'(1) << B_SOFTSEL;
    localparam logic [CTRL_W-1:0] WBASE = LOAD | PGMN | RSB | SSEL;
    localparam logic [CTRL_W-1:0] BBASE = LOAD | PGMN;

    logic [CTRL_W-1:0] baddr, waddr;

    always_comb begin
        baddr = CTRL_W'(addr) << BYTE_ASHIFT;
        waddr = CTRL_W'(addr) << WORD_ASHIFT;
        case (st)
            S_IDLE:   ctrl = word_mode ? (PDN | CSN) : (CSN | PGMN);
            S_SEL:    ctrl = CSN;
            S_LOAD:   ctrl = BBASE;
            S_ADDR:   ctrl = BBASE | baddr;
            S_WENTER: ctrl = WBASE;
            S_STRB:   ctrl = word_mode ? (WBASE | STRB | waddr) : (BBASE | STRB | baddr);
            S_LOW:    ctrl = word_mode ? (WBASE | waddr) : (BBASE | baddr);
            default:  ctrl = CSN;
        endcase
    end
endmodule

// File: rtl/fuse_read_seq.sv
module fuse_read_seq
    import fuse_seq_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int CNT_W      = 8,
    parameter int DATA_W     = 32,
    parameter int BYTE_DEPTH = 32,
    parameter int WORD_DEPTH = 128,
    parameter int CYC_PER_US = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_word,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_offset,
    input  logic [CNT_W-1:0]  req_count,
    output logic              req_ready,
    output logic [31:0]       fuse_ctrl,
    input  logic [DATA_W-1:0] fuse_dout,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              err
);
    localparam int TMR_W = $clog2(2 * CYC_PER_US + 1);
    localparam logic [TMR_W-1:0] WAIT1 = TMR_W'(CYC_PER_US - 1);
    localparam logic [TMR_W-1:0] WAIT2 = TMR_W'(2 * CYC_PER_US - 1);
    localparam int BYTE_W = 8;

    typedef struct packed {
        seq_st_e           st;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  left;
        logic              vld;
        logic [DATA_W-1:0] data;
        logic              done;
        logic              err;
    } regs_t;

    regs_t             d, q;
    logic [CTRL_W-1:0] ctrl_d, ctrl_q;
    logic              range_ok;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_exp;
    logic [DATA_W-1:0] sample;

    fuse_seq_range #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W),
        .BYTE_DEPTH(BYTE_DEPTH), .WORD_DEPTH(WORD_DEPTH)
    ) u_range (
        .word_mode(mode_word), .offset(req_offset), .count(req_count), .ok(range_ok)
    );

    fuse_seq_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
    );

    fuse_seq_pinmap #(.ADDR_W(ADDR_W)) u_pins (
        .word_mode(mode_word), .st(d.st), .addr(d.addr), .ctrl(ctrl_d)
    );

    generate
        if (DATA_W > BYTE_W) begin : g_wide
            assign sample = mode_word ? fuse_dout
                                      : {{(DATA_W-BYTE_W){1'b0}}, fuse_dout[BYTE_W-1:0]};
        end else begin : g_narrow
            assign sample = fuse_dout;
        end
    endgenerate

    always_comb begin
        d        = q;
        d.vld    = 1'b0;
        d.done   = 1'b0;
        d.err    = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    if (!range_ok) begin
                        d.err = 1'b1;
                    end else begin
                        d.addr = req_offset;
                        d.left = req_count;
                        if (mode_word) begin
                            d.st     = S_WENTER;
                            tmr_load = 1'b1;
                            tmr_val  = WAIT1;
                        end else begin
                            d.st = S_SEL;
                        end
                    end
                end
            end
            S_SEL: begin
                d.st     = S_LOAD;
                tmr_load = 1'b1;
                tmr_val  = WAIT2;
            end
            S_LOAD: begin
                if (tmr_exp) begin
                    d.st     = S_ADDR;
                    tmr_load = 1'b1;
                    tmr_val  = WAIT2;
                end
            end
            S_ADDR: begin
                if (tmr_exp) begin
                    d.st     = S_STRB;
                    tmr_load = 1'b1;
                    tmr_val  = WAIT2;
                end
            end
            S_WENTER: begin
                if (tmr_exp) begin
                    d.st     = S_STRB;
                    tmr_load = 1'b1;
                    tmr_val  = WAIT1;
                end
            end
            S_STRB: begin
                if (tmr_exp) begin
                    d.vld    = 1'b1;
                    d.data   = sample;
                    d.st     = S_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = mode_word ? WAIT1 : WAIT2;
                end
            end
            S_LOW: begin
                if (tmr_exp) begin
                    if (q.left == CNT_W'(1)) begin
                        d.st   = S_IDLE;
                        d.done = 1'b1;
                        d.left = '0;
                    end else begin
                        d.addr   = q.addr + 1'b1;
                        d.left   = q.left - 1'b1;
                        d.st     = mode_word ? S_STRB : S_ADDR;
                        tmr_load = 1'b1;
                        tmr_val  = mode_word ? WAIT1 : WAIT2;
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '{st: S_IDLE, default: '0};
            ctrl_q <= CTRL_W'(1) << B_CSN;
        end else begin
            q      <= d;
            ctrl_q <= ctrl_d;
        end
    end

    assign req_ready = (q.st == S_IDLE);
    assign fuse_ctrl = ctrl_q;
    assign rd_valid  = q.vld;
    assign rd_data   = q.data;
    assign done      = q.done;
    assign err       = q.err;
endmodule

// File: rtl/fuse_seq_chk.sv
module fuse_seq_chk #(
    parameter int DATA_W     = 32,
    parameter int CYC_PER_US = 25
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_word,
    input logic              req_ready,
    input logic [31:0]       fuse_ctrl,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              done,
    input logic              err
);
    localparam int HI_W = $clog2(2 * CYC_PER_US + 2) + 1;

    logic [31:0]     park;
    logic [HI_W-1:0] hi_cnt;
    logic [HI_W-1:0] hi_exp;

    assign park   = mode_word ? 32'h021 : 32'h009;
    assign hi_exp = mode_word ? HI_W'(CYC_PER_US) : HI_W'(2 * CYC_PER_US);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            hi_cnt <= '0;
        else if (fuse_ctrl[1]) hi_cnt <= hi_cnt + 1'b1;
        else                   hi_cnt <= '0;
    end

    p_idle_parked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !$past(req_ready)) |=> (fuse_ctrl == park && !fuse_ctrl[1]));

    p_strobe_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fuse_ctrl[1]) |-> (hi_cnt == hi_exp));  // R6 as well

    p_strobe_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_ctrl[1] && $past(fuse_ctrl[1])) |-> $stable(fuse_ctrl));

    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_byte_zero_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !mode_word) |-> (rd_data[DATA_W-1:8] == '0));

    p_done_parked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fuse_ctrl == park && req_ready && !rd_valid));

    p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (req_ready && !fuse_ctrl[1] && !rd_valid));

    p_busy_no_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !req_ready);
endmodule

bind fuse_read_seq fuse_seq_chk #(.DATA_W(DATA_W), .CYC_PER_US(CYC_PER_US)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .req_ready(req_ready),
    .fuse_ctrl(fuse_ctrl), .rd_valid(rd_valid), .rd_data(rd_data),
    .done(done), .err(err)
);

// File: tb/sim_fuse_read_seq.sv
module sim_fuse_read_seq;
    localparam int C = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_word = 1'b0;
    logic        req_valid = 1'b0;
    logic [9:0]  req_offset = '0;
    logic [7:0]  req_count = '0;
    logic        req_ready;
    logic [31:0] fuse_ctrl;
    logic [31:0] fuse_dout;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        done;
    logic        err;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    logic [31:0] log_v [0:63];
    int          log_t [0:63];
    int          log_n = 0;
    logic [31:0] prev_ctrl = '0;
    logic [31:0] rx [0:255];
    int          rx_n = 0;
    int          done_t = -1;
    int          done_n = 0;
    int          err_n = 0;

    always #5 clk = ~clk;

    fuse_read_seq #(.CYC_PER_US(C)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .req_valid(req_valid),
        .req_offset(req_offset), .req_count(req_count), .req_ready(req_ready),
        .fuse_ctrl(fuse_ctrl), .fuse_dout(fuse_dout), .rd_valid(rd_valid),
        .rd_data(rd_data), .done(done), .err(err)
    );

    function automatic logic [31:0] pat(input logic [9:0] a);
        pat = {a[7:0] ^ 8'h3C, a[7:0] + 8'h11, ~a[7:0], a[7:0]};
    endfunction

    // fuse macro model: data only valid while strobe is high
    always_comb begin
        if (fuse_ctrl[1])
            fuse_dout = pat(mode_word ? fuse_ctrl[25:16] : fuse_ctrl[15:6]);
        else
            fuse_dout = 32'hBAD0BAD0;
    end

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (fuse_ctrl != prev_ctrl && log_n < 64) begin
                log_v[log_n] = fuse_ctrl;
                log_t[log_n] = cyc;
                log_n++;
            end
            if (rd_valid && rx_n < 256) begin
                rx[rx_n] = rd_data;
                rx_n++;
            end
            if (done) begin
                done_t = cyc;
                done_n++;
            end
            if (err) err_n++;
        end
        prev_ctrl = fuse_ctrl;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        log_n = 0; rx_n = 0; done_t = -1; done_n = 0; err_n = 0;
    endtask

    task automatic run_req(input logic [9:0] off, input logic [7:0] cnt);
        @(negedge clk);
        req_offset = off; req_count = cnt; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 8000; i++) begin
            if (done_n != 0 || err_n != 0 || req_ready) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk);
        mode_word = m;
        repeat (3) @(negedge clk);
        clear_logs();
    endtask

    task automatic t_reset();
        check("R1 ready after reset", 32'(req_ready), 32'd1);
        check("R1 no valid after reset", 32'(rd_valid), 32'd0);
        check("R1 byte park word", fuse_ctrl, 32'h009);
    endtask

    task automatic t_byte_pins();
        set_mode(1'b0);
        run_req(10'd3, 8'd1);
        check("R3 R4 byte pin word count", 32'(log_n), 32'd6);
        check("R3 select alone", log_v[0], 32'h001);
        check("R3 load+pgm", log_v[1], 32'h00C);
        check("R2 byte addr field", log_v[2], 32'h0CC);
        check("R4 strobe high", log_v[3], 32'h0CE);
        check("R4 strobe low", log_v[4], 32'h0CC);
        check("R1 byte park after run", log_v[5], 32'h009);
        check("R3 select dwell", 32'(log_t[1] - log_t[0]), 32'd1);
        check("R3 load dwell", 32'(log_t[2] - log_t[1]), 32'(2*C));
        check("R4 addr setup dwell", 32'(log_t[3] - log_t[2]), 32'(2*C));
        check("R4 strobe dwell", 32'(log_t[4] - log_t[3]), 32'(2*C));
        check("R4 low dwell", 32'(log_t[5] - log_t[4]), 32'(2*C));
        check("R8 done with park", 32'(done_t), 32'(log_t[5]));
        check("R8 single done", 32'(done_n), 32'd1);
        check("R7 byte data", rx[0], 32'h0000_0003);
    endtask

    task automatic t_word_pins();
        set_mode(1'b1);
        check("R1 word park word", fuse_ctrl, 32'h021);
        run_req(10'd5, 8'd1);
        check("R5 R6 word pin word count", 32'(log_n), 32'd4);
        check("R5 word entry", log_v[0], 32'h28C);
        check("R2 R6 strobe with addr", log_v[1], 32'h0005_028E);
        check("R6 strobe low addr held", log_v[2], 32'h0005_028C);
        check("R1 word park after run", log_v[3], 32'h021);
        check("R5 entry dwell", 32'(log_t[1] - log_t[0]), 32'(C));
        check("R6 strobe dwell", 32'(log_t[2] - log_t[1]), 32'(C));
        check("R6 low dwell", 32'(log_t[3] - log_t[2]), 32'(C));
        check("R8 word done with park", 32'(done_t), 32'(log_t[3]));
        check("R7 word data", rx[0], pat(10'd5));
    endtask

    task automatic t_byte_full();
        int bad = 0;
        set_mode(1'b0);
        run_req(10'd0, 8'd32);
        check("R11 byte full array count", 32'(rx_n), 32'd32);
        for (int i = 0; i < 32; i++)
            if (rx[i] !== {24'h0, pat(10'(i))[7:0]}) bad++;
        check("R7 byte ascending data mismatches", 32'(bad), 32'd0);
        check("R7 byte last unit", rx[31], 32'h0000_001F);
    endtask

    task automatic t_word_full();
        int bad = 0;
        set_mode(1'b1);
        run_req(10'd0, 8'd128);
        check("R11 word full array count", 32'(rx_n), 32'd128);
        for (int i = 0; i < 128; i++)
            if (rx[i] !== pat(10'(i))) bad++;
        check("R7 word ascending data mismatches", 32'(bad), 32'd0);
        check("R8 word single done", 32'(done_n), 32'd1);
    endtask

    task automatic t_range();
        set_mode(1'b0);
        run_req(10'd30, 8'd3);
        check("R9 byte overrun err", 32'(err_n), 32'd1);
        check("R9 byte overrun no pins", 32'(log_n), 32'd0);
        check("R9 byte overrun no data", 32'(rx_n), 32'd0);
        clear_logs();
        run_req(10'd4, 8'd0);
        check("R9 zero count err", 32'(err_n), 32'd1);
        check("R9 zero count no pins", 32'(log_n), 32'd0);
        clear_logs();
        run_req(10'd31, 8'd1);
        check("R11 byte last offset accepted", 32'(err_n), 32'd0);
        check("R11 byte last offset data", rx[0], 32'h0000_001F);
        set_mode(1'b1);
        run_req(10'd120, 8'd9);
        check("R9 word overrun err", 32'(err_n), 32'd1);
        check("R9 word overrun no pins", 32'(log_n), 32'd0);
        clear_logs();
        run_req(10'd120, 8'd8);
        check("R11 word tail count", 32'(rx_n), 32'd8);
        check("R11 word last unit", rx[7], pat(10'd127));
    endtask

    task automatic t_busy();
        int ready_seen = 0;
        set_mode(1'b0);
        @(negedge clk);
        req_offset = 10'd2; req_count = 8'd2; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        ready_seen = req_ready;
        req_offset = 10'd10; req_count = 8'd5; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            if (done_n != 0) break;
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
        check("R10 ready low while busy", 32'(ready_seen), 32'd0);
        check("R10 only first run data", 32'(rx_n), 32'd2);
        check("R10 first unit", rx[0], 32'h0000_0002);
        check("R10 second unit", rx[1], 32'h0000_0003);
        check("R10 no extra done", 32'(done_n), 32'd1);
        check("R10 back to park", fuse_ctrl, 32'h009);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_byte_pins();
        t_word_pins();
        t_byte_full();
        t_word_full();
        t_range();
        t_busy();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule